// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one W-bit integer by another over several clock cycles and returns a W-bit quotient and a W-bit remainder. A mode input selects whether the operands are unsigned or two's-complement signed. Signed operation divides the magnitudes and then corrects the signs: the quotient truncates toward zero, and the remainder carries the sign of the dividend.

The datapath produces one quotient bit per cycle. A single shifting register of 2W+1 bits holds the partial remainder in its upper part, and the quotient bits collect in its lower W bits. The divisor register and the subtractor are W bits wide, plus a single carry bit. After the W steps, the upper part is shifted right by one position to give the remainder. The sign correction is applied in a final cycle.

A caller raises `start` for one cycle while `busy` is low. The caller then waits for the one-cycle `done` pulse. The results stay on the outputs until the next `done`. Dividing by zero raises no error and returns a fixed, defined result.

Top module: `seq_restoring_div`

## Requirements
- R1: While reset is held and after it is released, with no start yet seen, `busy`, `done`, `quotient` and `remainder` are all 0.
- R2: A start seen while idle makes `busy` high for exactly W+1 cycles. `done` is high in the cycle after the (W+2)th rising edge, counting the edge that sampled `start` as the first.
- R3: `done` is high for exactly one cycle per division. `quotient` and `remainder` change only in a cycle where `done` is high, and they hold their values afterwards.
- R4: With `sgn_mode` = 0 the operands are unsigned. The quotient is floor(dividend / divisor), and the remainder is dividend − quotient × divisor.
- R5: With `sgn_mode` = 1 the operands are two's complement. The quotient is the true quotient truncated toward zero, and it is negative when exactly one operand is negative.
- R6: In signed mode a nonzero remainder has the sign of the dividend, and its magnitude is below the magnitude of the divisor (−7 / 2 gives quotient −3 and remainder −1).
- R7: A divisor of 0 in either mode gives a quotient with every bit 1 and a remainder equal to the dividend as supplied.
- R8: In signed mode, the most negative value divided by −1 gives a quotient equal to the dividend and a remainder of 0.
- R9: `start` is ignored while `busy` is high. Changes to the operand or mode inputs after the start cycle have no effect on the result that is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request a division; sampled only while idle |
| sgn_mode | input | 1 | 1 = signed two's-complement operands, 0 = unsigned |
| dividend | input | W | Dividend, captured on the start cycle |
| divisor | input | W | Divisor, captured on the start cycle |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when new results are on the outputs |
| quotient | output | W | Quotient of the last completed division |
| remainder | output | W | Remainder of the last completed division |

## Verification
The bound checker observes the handshake on every cycle. It checks that `done` is a single-cycle pulse that appears only after `busy` falls, that the busy interval is exactly W+1 cycles long, that a start raised while busy does not cut the run short, and that the outputs stay unchanged outside `done`.

The arithmetic can only be shown by the bench's scenarios. These cover unsigned and signed quotient values, the remainder sign rule, divide by zero in both modes, the most-negative value divided by −1, and operands that change while a division is running.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/div_mag.sv
// Magnitude of an operand: negated when signed mode is on and the sign bit is set.
module div_mag #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         sgn_en,
  output logic [W-1:0] mag,
  output logic         neg
);
  assign neg = sgn_en & val[W-1];
  assign mag = neg ? (~val + W'(1)) : val;
endmodule

// File: rtl/div_step.sv
// One restoring step: trial subtraction on the upper part, keep or restore,
// then shift the whole register left with the new quotient bit at the bottom.
module div_step #(
  parameter int W = 16
) (
  input  logic [W:0]   hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvs,
  output logic [W:0]   hi_nx,
  output logic [W-1:0] lo_nx
);
  logic [W:0]   diff;
  logic         qbit;
  logic [W-1:0] kept;

  always_comb begin
    diff  = hi - {1'b0, dvs};
    qbit  = ~diff[W];
    kept  = qbit ? diff[W-1:0] : hi[W-1:0];
    hi_nx = {kept, lo[W-1]};
    lo_nx = {lo[W-2:0], qbit};
  end
endmodule

// File: rtl/div_fix.sv
// Final correction: right shift of the upper part, sign fix, divide-by-zero result.
module div_fix #(
  parameter int W = 16
) (
  input  logic [W:0]   core_hi,
  input  logic [W-1:0] core_lo,
  input  logic         q_neg,
  input  logic         r_neg,
  input  logic         dvs_zero,
  input  logic [W-1:0] dvd_raw,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] r_mag;

  always_comb begin
    r_mag = core_hi[W:1];
    if (dvs_zero) begin
      quo = '1;
      rem = dvd_raw;
    end else begin
      quo = q_neg ? (~core_lo + W'(1)) : core_lo;
      rem = r_neg ? (~r_mag + W'(1)) : r_mag;
    end
  end
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int            CW   = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic rst_s_n;

  div_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_s_n)
  );

  // operand magnitudes
  logic [W-1:0] mag [2];
  logic [1:0]   negf;
  logic [W-1:0] opnd [2];

  assign opnd[0] = dividend;
  assign opnd[1] = divisor;

  for (genvar g = 0; g < 2; g++) begin : g_mag
    div_mag #(.W(W)) u_mag (
      .val   (opnd[g]),
      .sgn_en(sgn_mode),
      .mag   (mag[g]),
      .neg   (negf[g])
    );
  end

  // state
  div_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]    hi_q, hi_d, hi_step;
  logic [W-1:0]  lo_q, lo_d, lo_step;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [W-1:0]  dvd_q, dvd_d;
  logic          qneg_q, qneg_d, rneg_q, rneg_d, zero_q, zero_d;
  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d, fix_q, fix_r;
  logic          done_q, done_d;
  logic          load_en, step_en, fin_en;

  div_step #(.W(W)) u_step (
    .hi   (hi_q),
    .lo   (lo_q),
    .dvs  (dvs_q),
    .hi_nx(hi_step),
    .lo_nx(lo_step)
  );

  div_fix #(.W(W)) u_fix (
    .core_hi (hi_q),
    .core_lo (lo_q),
    .q_neg   (qneg_q),
    .r_neg   (rneg_q),
    .dvs_zero(zero_q),
    .dvd_raw (dvd_q),
    .quo     (fix_q),
    .rem     (fix_r)
  );

  assign load_en = (state_q == ST_IDLE) && start;
  assign step_en = (state_q == ST_RUN);
  assign fin_en  = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    dvs_d  = dvs_q;
    dvd_d  = dvd_q;
    qneg_d = qneg_q;
    rneg_d = rneg_q;
    zero_d = zero_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    done_d = fin_en;
    if (load_en) begin
      // initial left shift of {0, |dividend|}
      hi_d   = {{W{1'b0}}, mag[0][W-1]};
      lo_d   = {mag[0][W-2:0], 1'b0};
      dvs_d  = mag[1];
      dvd_d  = dividend;
      qneg_d = negf[0] ^ negf[1];
      rneg_d = negf[0];
      zero_d = (divisor == '0);
      cnt_d  = '0;
    end else if (step_en) begin
      hi_d  = hi_step;
      lo_d  = lo_step;
      cnt_d = cnt_q + 1'b1;
    end
    if (fin_en) begin
      quo_d = fix_q;
      rem_d = fix_r;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      dvs_q   <= '0;
      dvd_q   <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      zero_q  <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      dvs_q   <= dvs_d;
      dvd_q   <= dvd_d;
      qneg_q  <= qneg_d;
      rneg_q  <= rneg_d;
      zero_q  <= zero_d;
      quo_q   <= quo_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/div_chk.sv
module div_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int BW = $clog2(W + 3);

  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder))); // R3

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_run == BW'(W + 1))); // R2

  AST_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (busy_run < BW'(W))) |=> busy); // R9
endmodule

bind seq_restoring_div div_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .quotient (quotient),
  .remainder(remainder)
);

// File: tb/seq_restoring_div_tb.sv
module seq_restoring_div_tb;
  localparam int W = 16;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sgn_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  seq_restoring_div #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input bit s, output logic [W-1:0] q,
                                output logic [W-1:0] r);
    if (b == '0) begin
      q = '1; r = a;
    end else if (!s) begin
      q = a / b; r = a % b;
    end else if (a == MINV && b == '1) begin
      q = a; r = '0;
    end else begin
      logic signed [W-1:0] sa, sb;
      sa = a; sb = b;
      q = sa / sb; r = sa % sb;
    end
  endfunction

  // one division; poke = raise start with other operands while busy
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                         input bit poke, input string req);
    logic [W-1:0] eq, er, hq, hr;
    int n;
    model(a, b, s, eq, er);
    @(negedge clk);
    dividend = a; divisor = b; sgn_mode = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(busy == 1'b1, "R2 busy after start", W'(busy), W'(1));
    if (poke) begin
      dividend = ~a; divisor = b + W'(3); sgn_mode = ~s; start = 1'b1;
    end
    while (!done && n < 100) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 4) start = 1'b0;
    end
    check(n == W + 2, "R2 latency", W'(n), W'(W + 2));
    check(quotient == eq, {req, " quotient"}, quotient, eq);
    check(remainder == er, {req, " remainder"}, remainder, er);
    hq = quotient; hr = remainder;
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", W'(done), W'(0));
    repeat (2) @(negedge clk);
    check(quotient == hq && remainder == hr, "R3 outputs held", quotient, hq);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, '0);
    check(quotient == '0 && remainder == '0, "R1 reset data", quotient | remainder, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && quotient == '0, "R1 after release", quotient, '0);
  endtask

  task automatic t_unsigned();
    run_div(16'd100, 16'd7, 1'b0, 1'b0, "R4 100/7");
    run_div(16'hFFFF, 16'd1, 1'b0, 1'b0, "R4 max/1");
    run_div(16'd5, 16'd9, 1'b0, 1'b0, "R4 small/large");
    run_div(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R4 max/max");
    run_div(16'd40000, 16'd123, 1'b0, 1'b0, "R4 40000/123");
    run_div(16'h8000, 16'hFFFE, 1'b0, 1'b0, "R4 top bits");
  endtask

  task automatic t_signed();
    run_div(-16'sd7, 16'sd2, 1'b1, 1'b0, "R6 -7/2");
    run_div(16'sd7, -16'sd2, 1'b1, 1'b0, "R5 7/-2");
    run_div(-16'sd7, -16'sd2, 1'b1, 1'b0, "R6 -7/-2");
    run_div(16'sd7, 16'sd2, 1'b1, 1'b0, "R5 7/2");
    run_div(MINV, 16'sd3, 1'b1, 1'b0, "R5 min/3");
    run_div(-16'sd1, 16'sd32767, 1'b1, 1'b0, "R6 -1/max");
  endtask

  task automatic t_special();
    run_div(16'd1234, 16'd0, 1'b0, 1'b0, "R7 unsigned by zero");
    run_div(-16'sd5, 16'd0, 1'b1, 1'b0, "R7 signed by zero");
    run_div(MINV, 16'hFFFF, 1'b1, 1'b0, "R8 min/-1");
  endtask

  task automatic t_ignore();
    run_div(16'd1000, 16'd33, 1'b0, 1'b1, "R9 start while busy");
    run_div(-16'sd300, 16'sd7, 1'b1, 1'b1, "R9 signed inputs change");
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      x = x * 32'd1103515245 + 32'd12345;
      a = x[30:15];
      x = x * 32'd1103515245 + 32'd12345;
      b = (i % 3 == 0) ? W'(x[20:15]) : x[30:15];
      run_div(a, b, i[0], 1'b0, (i[0] ? "R5 sweep" : "R4 sweep"));
    end
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_special();
    t_ignore();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule